// File: doc/BRIEF.md
# Page access fault detector

This block sits beside an address translation path and judges every memory access against the attributes of the page it lands in. For each access the block takes the virtual address, the read or write flag, the 2-bit current privilege level and three page attributes: present, writable and user-accessible. It then decides whether the access must raise a page fault.

When an access faults, the block raises a one-cycle fault pulse that carries exception vector 0x0E. It also builds a small error code that tells the handler why the access failed, and it loads the full faulting virtual address into a fault address register. Accesses that do not fault leave both the error code and the captured address as they were. Delivering the error code to a stack and entering the handler are left to the surrounding logic.

The results are registered. An access presented with `acc_valid` high at one rising clock edge has its outcome on the outputs right after that edge.

Top module: `pgf_detector`

## Requirements
- R1: Privilege level 3 counts as user; levels 0, 1 and 2 count as supervisor. Error code bit 2 is 1 exactly when a faulting access was made at level 3.
- R2: An access to a page whose present flag is 0 faults, whatever the writable and user flags say.
- R3: A write to a present page whose writable flag is 0 faults, at every privilege level.
- R4: A level-3 access to a present page whose user flag is 0 faults, for reads and writes alike.
- R5: A valid access that meets none of the conditions in R2, R3 and R4 does not fault.
- R6: Error code bit 0 is 0 for a fault caused by a not-present page and 1 for a protection fault on a present page. Presence is checked first.
- R7: Error code bit 1 is 1 when the faulting access was a write and 0 when it was a read.
- R8: Error code bits 3 and above are always 0.
- R9: On every fault, `fault_addr` takes the full 32-bit virtual address of the faulting access, in the same cycle that `fault_pulse` is high.
- R10: Reset clears `fault_addr` and `fault_code` to zero and `fault_pulse` to 0. A cycle without a fault leaves `fault_addr` and `fault_code` unchanged.
- R11: `fault_vector` reads 0x0E while `fault_pulse` is high and 0x00 otherwise.
- R12: `fault_pulse` goes high for exactly one cycle, in the cycle after the edge that samples a faulting access with `acc_valid` high. When `acc_valid` is low, no fault is raised, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_vaddr | input | 32 | Virtual address of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_cpl | input | 2 | Current privilege level (3 = user) |
| pg_present | input | 1 | Page present attribute |
| pg_writable | input | 1 | Page writable attribute |
| pg_user | input | 1 | Page user-accessible attribute |
| fault_pulse | output | 1 | One-cycle page fault indication |
| fault_vector | output | 8 | Exception vector, 0x0E during a fault |
| fault_code | output | 4 | Error code of the latest fault |
| fault_addr | output | 32 | Virtual address of the latest fault |

## Verification
Two situations are hard to reach from the ports. The first is a not-present page that also violates the permission flags, where bit 0 of the error code must still read 0. The second is a run of non-faulting and invalid accesses that must leave an earlier captured address in place. The bench sweeps every combination of the write flag, the four privilege levels and the three page flags, with a different address for each access. Between sweep points it inserts idle cycles, and it also presents faulting attribute patterns with `acc_valid` low. As a result, every captured address and error code has to survive traffic that would have overwritten it if the hold logic were wrong.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

    localparam int ADDR_W   = 32;
    localparam int CPL_W    = 2;
    localparam int CODE_W   = 4;
    localparam int VEC_W    = 8;
    localparam logic [CPL_W-1:0] USER_CPL = 2'd3;
    localparam logic [VEC_W-1:0] PF_VECTOR = 8'h0E;

    // bit positions inside the error code (decoded by the fault handler)
    localparam int CODE_PROT_BIT  = 0;
    localparam int CODE_WRITE_BIT = 1;
    localparam int CODE_USER_BIT  = 2;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_ABSENT = 2'd1,
        CAUSE_RDONLY = 2'd2,
        CAUSE_PRIV   = 2'd3
    } pgf_cause_e;

    typedef struct packed {
        logic              write;
        logic [CPL_W-1:0]  cpl;
        logic              present;
        logic              writable;
        logic              user;
    } pgf_access_t;

    typedef struct packed {
        logic              fault;
        logic [CODE_W-1:0] code;
    } pgf_verdict_t;

    function automatic logic is_user_level(input logic [CPL_W-1:0] cpl);
        return cpl == USER_CPL;
    endfunction

    function automatic logic is_fault(input pgf_cause_e cause);
        return cause != CAUSE_NONE;
    endfunction

endpackage

// File: rtl/pgf_classify.sv
module pgf_classify
    import pgf_pkg::*;
(
    input  pgf_access_t acc,
    output pgf_cause_e  cause
);

    logic user_lvl;

    assign user_lvl = is_user_level(acc.cpl);

    // presence is judged before any permission flag
    always_comb begin
        cause = CAUSE_NONE;
        if (!acc.present) begin
            cause = CAUSE_ABSENT;
        end else if (acc.write && !acc.writable) begin
            cause = CAUSE_RDONLY;
        end else if (user_lvl && !acc.user) begin
            cause = CAUSE_PRIV;
        end
    end

endmodule

// File: rtl/pgf_errcode.sv
module pgf_errcode
    import pgf_pkg::*;
(
    input  pgf_access_t  acc,
    input  pgf_cause_e   cause,
    output pgf_verdict_t verdict
);

    always_comb begin
        verdict.fault                = is_fault(cause);
        verdict.code                 = '0;
        verdict.code[CODE_PROT_BIT]  = (cause == CAUSE_RDONLY) || (cause == CAUSE_PRIV);
        verdict.code[CODE_WRITE_BIT] = acc.write;
        verdict.code[CODE_USER_BIT]  = is_user_level(acc.cpl);
    end

endmodule

// File: rtl/pgf_capture.sv
module pgf_capture
    import pgf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [ADDR_W-1:0] vaddr,
    input  pgf_verdict_t      verdict,
    output logic              pulse,
    output logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] addr
);

    logic take;

    assign take = valid && verdict.fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
            code  <= '0;
            addr  <= '0;
        end else begin
            pulse <= take;
            if (take) begin
                code <= verdict.code;
                addr <= vaddr;
            end
        end
    end

endmodule

// File: rtl/pgf_detector.sv
module pgf_detector
    import pgf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [31:0]       acc_vaddr,
    input  logic              acc_write,
    input  logic [1:0]        acc_cpl,
    input  logic              pg_present,
    input  logic              pg_writable,
    input  logic              pg_user,
    output logic              fault_pulse,
    output logic [7:0]        fault_vector,
    output logic [3:0]        fault_code,
    output logic [31:0]       fault_addr
);

    pgf_access_t  acc;
    pgf_cause_e   cause;
    pgf_verdict_t verdict;

    always_comb begin
        acc.write    = acc_write;
        acc.cpl      = acc_cpl;
        acc.present  = pg_present;
        acc.writable = pg_writable;
        acc.user     = pg_user;
    end

    pgf_classify u_classify (
        .acc   (acc),
        .cause (cause)
    );

    pgf_errcode u_errcode (
        .acc     (acc),
        .cause   (cause),
        .verdict (verdict)
    );

    pgf_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .valid   (acc_valid),
        .vaddr   (acc_vaddr),
        .verdict (verdict),
        .pulse   (fault_pulse),
        .code    (fault_code),
        .addr    (fault_addr)
    );

    assign fault_vector = fault_pulse ? PF_VECTOR : '0;

    AST_PULSE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> $past(acc_valid)); // R12
    AST_ABSENT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (fault_pulse && !$past(pg_present)) |-> !fault_code[0]); // R6
    AST_WRITE_BIT: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> (fault_code[1] == $past(acc_write))); // R7
    AST_USER_BIT: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> (fault_code[2] == ($past(acc_cpl) == 2'd3))); // R1
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        fault_code[3] == 1'b0); // R8
    AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> (fault_addr == $past(acc_vaddr))); // R9
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fault_pulse |-> ($stable(fault_addr) && $stable(fault_code))); // R10
    AST_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !pg_present) |=> fault_pulse); // R2
    AST_CLEAN_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && pg_present && (!acc_write || pg_writable)
         && (acc_cpl != 2'd3 || pg_user)) |=> !fault_pulse); // R5

endmodule

// File: tb/pgf_detector_test.sv
`timescale 1ns/1ps
module pgf_detector_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_vaddr = '0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_cpl = '0;
    logic        pg_present = 1'b0;
    logic        pg_writable = 1'b0;
    logic        pg_user = 1'b0;
    logic        fault_pulse;
    logic [7:0]  fault_vector;
    logic [3:0]  fault_code;
    logic [31:0] fault_addr;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_addr = '0;
    logic [3:0]  exp_code = '0;

    always #10 clk = ~clk;

    pgf_detector uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
        .acc_write(acc_write), .acc_cpl(acc_cpl), .pg_present(pg_present),
        .pg_writable(pg_writable), .pg_user(pg_user), .fault_pulse(fault_pulse),
        .fault_vector(fault_vector), .fault_code(fault_code), .fault_addr(fault_addr)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        chk(fault_pulse == 1'b0, req, {31'd0, fault_pulse}, 32'd0);
        chk(fault_vector == 8'h00, {req, " R11 vector"}, {24'd0, fault_vector}, 32'd0);
        chk(fault_addr == exp_addr, {req, " R10 addr hold"}, fault_addr, exp_addr);
        chk(fault_code == exp_code, {req, " R10 code hold"}, {28'd0, fault_code}, {28'd0, exp_code});
    endtask

    task automatic access(input logic v, input logic [31:0] a, input logic w,
                          input logic [1:0] c, input logic p, input logic wr, input logic u);
        logic flt;
        @(negedge clk);
        acc_valid = v; acc_vaddr = a; acc_write = w; acc_cpl = c;
        pg_present = p; pg_writable = wr; pg_user = u;
        flt = v && (!p || (w && !wr) || (c == 2'd3 && !u));
        @(negedge clk);
        acc_valid = 1'b0;
        if (flt) begin
            exp_addr = a;
            exp_code = {1'b0, c == 2'd3, w, p};
            chk(fault_pulse == 1'b1, !p ? "R2 absent fault" : (w && !wr) ? "R3 read-only fault" : "R4 privilege fault",
                {31'd0, fault_pulse}, 32'd1);
            chk(fault_vector == 8'h0E, "R11 vector", {24'd0, fault_vector}, 32'h0E);
            chk(fault_code[0] == p, "R6 cause bit", {28'd0, fault_code}, {28'd0, exp_code});
            chk(fault_code[1] == w, "R7 write bit", {28'd0, fault_code}, {28'd0, exp_code});
            chk(fault_code[2] == (c == 2'd3), "R1 user bit", {28'd0, fault_code}, {28'd0, exp_code});
            chk(fault_code[3] == 1'b0, "R8 reserved", {28'd0, fault_code}, {28'd0, exp_code});
            chk(fault_addr == a, "R9 address capture", fault_addr, a);
        end else begin
            check_idle(v ? "R5 no fault" : "R12 invalid ignored");
        end
        // pulse lasts one cycle only
        @(negedge clk);
        chk(fault_pulse == 1'b0, "R12 single cycle", {31'd0, fault_pulse}, 32'd0);
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R10 reset state");
        rst = 1'b0;
        // full sweep, valid high
        for (int i = 0; i < 32; i++) begin
            for (int c = 0; c < 4; c++) begin
                access(1'b1, (i * 32'h0813_3FC5) ^ (c * 32'h4000_1003) ^ 32'hA5A5_0F0F,
                       i[4], c[1:0], i[2], i[1], i[0]);
            end
        end
        // faulting patterns with valid low must be ignored
        for (int i = 0; i < 8; i++) begin
            access(1'b0, 32'hDEAD_0000 + i, 1'b1, 2'd3, 1'b0, i[1], i[0]);
        end
        // clean accesses after a fault keep the captured state
        access(1'b1, 32'hFFFF_F000, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1);
        access(1'b1, 32'h0000_0001, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0);
        access(1'b1, 32'h1234_5678, 1'b1, 2'd3, 1'b1, 1'b1, 1'b1);
        // mid-run reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        exp_addr = '0; exp_code = '0;
        check_idle("R10 reset clears");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule